// File: doc/BRIEF.md
# Register-Mapped Integer Square Root Unit

This unit returns the floor of the square root of an unsigned operand that software places in a 64-bit parameter register. A control register picks whether the whole parameter or only its lower half is the operand. Any write to the control register or to either half of the parameter starts a new computation. While it runs, a busy flag in the control register reads as one. The 32-bit root is stored in a result register, and the busy flag drops once that result is in place.

The datapath uses a digit-by-digit recurrence built from shifts, one adder and one comparator. There is no multiplier. A leading-pair detector places the trial bit at the highest even position that does not exceed the operand, so small operands finish early. Each clock then resolves one root bit. A write that arrives while a computation runs throws that computation away and starts again from the register contents as they are after the write.

Top module: `isqrt_mmio`

## Requirements
- R1: Control register (word address 0) bit 0 selects the operand width: 1 uses all 64 parameter bits, 0 uses only parameter bits 31:0 and ignores the upper word.
- R2: A write to address 0, 1 (parameter bits 31:0) or 2 (parameter bits 63:32) starts a computation, and control bit 15 (busy) reads 1 from the cycle after that write.
- R3: Address 3 returns floor(sqrt(operand)) in bits 31:0 once busy reads 0.
- R4: Busy clears only when the result has been stored. For a zero operand the result is 0 and busy reads 0 within 2 cycles after the starting write.
- R5: A computation uses at most 32 iterations, one per clock, and busy reads 0 no later than 35 cycles after the starting write.
- R6: A start write while busy aborts the running computation. The final result belongs to the operand as it stands after the last write, including a write in the same cycle that the previous computation completes.
- R7: Writes to address 3 change no register and do not start a computation. Control bits other than 0 and 15 read as 0.
- R8: After reset every register reads 0 and busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |

## Verification
Two functions can collide in one cycle: a running computation storing its root and clearing busy, and a new start write from the bus. The bench provokes this by timing a parameter write onto the exact cycle in which a one-iteration computation completes. It then requires that busy stays set and that the final result is the root of the newly written operand. Aborts in the middle of a long 64-bit computation are checked the same way, against roots computed in the bench by a binary search on squares.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;
    localparam int SQ_OP_W   = 64;
    localparam int SQ_ROOT_W = SQ_OP_W / 2;
    localparam int SQ_BUS_W  = 32;
    localparam int SQ_ADDR_W = 2;
    localparam int SQ_BUSY_BIT = 15;
    localparam int SQ_CNT_W  = $clog2(SQ_ROOT_W) + 1;

    typedef enum logic [SQ_ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PHI  = 2'd2,
        SEL_ROOT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SQ_OP_W-1:0] rem;    // remaining operand
        logic [SQ_OP_W-1:0] acc;    // partial root (scaled)
        logic [SQ_OP_W-1:0] probe;  // one-hot trial bit, even position
    } sq_state_t;

    function automatic logic [SQ_OP_W-1:0] mask_operand(
        input logic [SQ_OP_W-1:0] value, input logic wide);
        return wide ? value : {{(SQ_OP_W-SQ_BUS_W){1'b0}}, value[SQ_BUS_W-1:0]};
    endfunction
endpackage

// File: rtl/sqrt_lead.sv
module sqrt_lead
    import sqrt_pkg::*;
#(
    parameter int OP_W = SQ_OP_W
) (
    input  logic [OP_W-1:0] value,
    output logic [OP_W-1:0] start_probe
);
    localparam int PAIRS = OP_W / 2;

    logic [PAIRS-1:0] pair_nz;

    generate
        for (genvar g = 0; g < PAIRS; g++) begin : g_pair
            assign pair_nz[g] = value[2*g] | value[2*g+1];
        end
    endgenerate

    always_comb begin
        logic found;
        found = 1'b0;
        start_probe = '0;
        for (int i = PAIRS - 1; i >= 0; i--) begin
            if (!found && pair_nz[i]) begin
                start_probe[2*i] = 1'b1;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sqrt_core.sv
module sqrt_core
    import sqrt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [SQ_OP_W-1:0]   operand,
    output logic                 active,
    output logic                 done,
    output logic [SQ_ROOT_W-1:0] root
);
    sq_state_t          st_q;
    sq_state_t          st_n;
    logic [SQ_OP_W-1:0] start_probe;
    logic [SQ_OP_W-1:0] trial;
    logic               take;
    logic               last;
    logic               active_q;
    logic               done_q;
    logic [SQ_ROOT_W-1:0] root_q;
    logic [SQ_CNT_W-1:0]  iter_q;

    sqrt_lead #(.OP_W(SQ_OP_W)) u_lead (
        .value       (operand),
        .start_probe (start_probe)
    );

    always_comb begin
        trial      = st_q.acc + st_q.probe;
        take       = st_q.rem >= trial;
        st_n.rem   = take ? st_q.rem - trial : st_q.rem;
        st_n.acc   = take ? (st_q.acc >> 1) + st_q.probe : st_q.acc >> 1;
        st_n.probe = st_q.probe >> 2;
        last       = st_q.probe[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            root_q   <= '0;
            iter_q   <= '0;
        end else if (load) begin
            st_q.rem   <= operand;
            st_q.acc   <= '0;
            st_q.probe <= start_probe;
            iter_q     <= '0;
            if (operand == '0) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
                root_q   <= '0;
            end else begin
                active_q <= 1'b1;
                done_q   <= 1'b0;
            end
        end else if (active_q) begin
            st_q   <= st_n;
            iter_q <= iter_q + 1'b1;
            if (last) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
                root_q   <= st_n.acc[SQ_ROOT_W-1:0];
            end else begin
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign active = active_q;
    assign done   = done_q;
    assign root   = root_q;

    // R5: never more iterations than root bits
    p_iter_limit_r5: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (iter_q < SQ_CNT_W'(SQ_ROOT_W)));

    // R5: the trial bit is a single bit while iterating
    p_probe_single_r5: assert property (@(posedge clk) disable iff (rst)
        active_q |-> ($countones(st_q.probe) == 1));

    // R3: stored root only moves when a completion is flagged
    p_root_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(root_q));
endmodule

// File: rtl/isqrt_mmio.sv
module isqrt_mmio
    import sqrt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [SQ_ADDR_W-1:0] bus_addr,
    input  logic [SQ_BUS_W-1:0]  bus_wdata,
    output logic [SQ_BUS_W-1:0]  bus_rdata
);
    logic                 wide_q;
    logic                 busy_q;
    logic                 start_q;
    logic [SQ_OP_W-1:0]   param_q;
    logic                 start_wr;
    logic                 core_active;
    logic                 core_done;
    logic [SQ_ROOT_W-1:0] core_root;
    reg_sel_e             sel;

    assign sel      = reg_sel_e'(bus_addr);
    assign start_wr = bus_wr && (sel != SEL_ROOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q  <= 1'b0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            param_q <= '0;
        end else begin
            start_q <= start_wr;
            if (bus_wr) begin
                unique case (sel)
                    SEL_CTRL: wide_q <= bus_wdata[0];
                    SEL_PLO:  param_q[SQ_BUS_W-1:0] <= bus_wdata;
                    SEL_PHI:  param_q[SQ_OP_W-1:SQ_BUS_W] <= bus_wdata;
                    default:  ;
                endcase
            end
            if (start_wr) begin
                busy_q <= 1'b1;
            end else if (core_done && !start_q) begin
                busy_q <= 1'b0;
            end
        end
    end

    sqrt_core u_core (
        .clk     (clk),
        .rst     (rst),
        .load    (start_q),
        .operand (mask_operand(param_q, wide_q)),
        .active  (core_active),
        .done    (core_done),
        .root    (core_root)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                bus_rdata[0]           = wide_q;
                bus_rdata[SQ_BUSY_BIT] = busy_q;
            end
            SEL_PLO:  bus_rdata = param_q[SQ_BUS_W-1:0];
            SEL_PHI:  bus_rdata = param_q[SQ_OP_W-1:SQ_BUS_W];
            default:  bus_rdata = core_root;
        endcase
    end

    // R2: a start write raises busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> busy_q);

    // R4: a completion with no pending start drops busy
    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (core_done && !start_wr && !start_q) |=> !busy_q);

    // R6: while a computation runs the flag stays raised
    p_active_busy_r6: assert property (@(posedge clk) disable iff (rst)
        core_active |-> busy_q);
endmodule

// File: tb/test_isqrt_mmio.sv
module test_isqrt_mmio;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    isqrt_mmio i_isqrt_mmio (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ref_root(input logic [63:0] x);
        logic [31:0]  r;
        logic [31:0]  c;
        logic [127:0] sq;
        r = '0;
        for (int b = 31; b >= 0; b--) begin
            c  = r | (32'd1 << b);
            sq = 128'(c) * 128'(c);
            if (sq <= 128'(x)) r = c;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // wait until busy reads 0, returning negedges waited after the write
    task automatic wait_idle(output int cyc);
        logic [31:0] v;
        cyc = 0;
        rd(2'd0, v);
        while (v[15] && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            rd(2'd0, v);
        end
    endtask

    task automatic run_op(input logic [63:0] x, input bit wide, input string tag);
        logic [31:0] v;
        logic [63:0] eff;
        int cyc;
        wr(2'd0, {31'd0, wide});
        wr(2'd1, x[31:0]);
        wr(2'd2, x[63:32]);
        rd(2'd0, v);
        check(v[15] == 1'b1, "R2", 64'(v[15]), 64'd1);
        wait_idle(cyc);
        check(cyc <= 35, "R5", 64'(cyc), 64'd35);
        eff = wide ? x : {32'd0, x[31:0]};
        rd(2'd3, v);
        check(v == ref_root(eff), wide ? {"R3 R1 ", tag} : {"R1 R3 ", tag},
              64'(v), 64'(ref_root(eff)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [63:0] x;
        int cyc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 32'd0, "R8", 64'(v), 64'd0);
        end
        // corners in both width modes
        for (int m = 0; m < 2; m++) begin
            run_op(64'd0, m[0], "zero");
            run_op(64'd1, m[0], "one");
            run_op(64'd2, m[0], "two");
            run_op(64'h0000_0000_FFFF_FFFF, m[0], "2^32-1");
            run_op(64'hFFFF_FFFF_FFFF_FFFF, m[0], "2^64-1");
            run_op(64'h0000_0001_0000_0000, m[0], "2^32");
            run_op(64'hFFFF_FFFE_0000_0001, m[0], "square");
        end
        // R4 zero operand: busy gone within 2 cycles
        wr(2'd0, 32'd1);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd0);
        wait_idle(cyc);
        check(cyc <= 2, "R4 zero latency", 64'(cyc), 64'd2);
        rd(2'd3, v);
        check(v == 32'd0, "R4 zero root", 64'(v), 64'd0);
        // R7 write to result address ignored, no start
        wr(2'd1, 32'd1000000);
        wait_idle(cyc);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd0, v);
        check(v == 32'd1, "R7 no start / other ctrl bits", 64'(v), 64'd1);
        rd(2'd3, v);
        check(v == 32'd1000, "R7 result kept", 64'(v), 64'd1000);
        // R6 abort in the middle of a long computation
        wr(2'd0, 32'd1);
        wr(2'd1, 32'h1234_5678);
        wr(2'd2, 32'hFFFF_0000);
        repeat (5) @(negedge clk);
        wr(2'd2, 32'h0000_0001);
        wait_idle(cyc);
        rd(2'd3, v);
        check(v == ref_root(64'h0000_0001_1234_5678), "R6 mid abort", 64'(v),
              64'(ref_root(64'h0000_0001_1234_5678)));
        // R6 start write landing on the completion cycle
        wr(2'd2, 32'd0);
        wait_idle(cyc);
        wr(2'd1, 32'd1);              // one-iteration computation
        repeat (1) @(negedge clk);
        wr(2'd2, 32'h0000_0100);      // strobe covers the completion edge
        rd(2'd0, v);
        check(v[15] == 1'b1, "R6 collide busy", 64'(v[15]), 64'd1);
        wait_idle(cyc);
        rd(2'd3, v);
        check(v == 32'h0010_0000, "R6 collide root", 64'(v), 64'h0010_0000);
        // constrained random, both modes
        for (int k = 0; k < 60; k++) begin
            x = {$urandom(), $urandom()};
            if (k % 3 == 0) x = x >> ($urandom() % 64);
            run_op(x, k[0], "random");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule